// File: doc/BRIEF.md
# Five-Level Leg Gate Decoder

This block drives the eight gates of one phase leg of a five-level hybrid inverter. The leg holds two flying capacitors: one serves only the positive half of the output swing and the other only the negative half. Each clock the block samples a signed level command (+2, +1, 0, -1, -2), the direction of the load current and one "below target" flag per capacitor. It then produces four main gate signals and their four complements.

The command is split into a positive-half and a negative-half three-level command. A two-bit cell decoder turns each half into the gate pair of its own cell. Levels +1 and -1 can each be reached through two redundant switch states. The block picks the state that moves the capacitor of that half toward its target, given the current direction. The choice is made when the level is entered and kept until the command changes. The level command, capacitor sensing and dead time are produced elsewhere.

Top module: `leg_gate_decoder`

## Requirements
- R1: Code 3'b010 (+2) gives gate_main = 4'b1111, and code 3'b110 (-2) gives gate_main = 4'b0000. gate_main is written as {S1,S2,S3,S4}, with S1 on bit 3.
- R2: Code 3'b000 (0) gives gate_main = 4'b0011, which clamps the output to the neutral point.
- R3: On entry to code 3'b001 (+1), gate_main is 4'b1011 when cur_pos equals fc1_low, and 4'b0111 otherwise. cur_pos = 1 means outbound current. fc1_low = 1 means the first capacitor is below target.
- R4: On entry to code 3'b111 (-1), gate_main is 4'b0010 when cur_pos equals fc2_low, and 4'b0001 otherwise. fc2_low = 1 means the second capacitor is below target.
- R5: While the level code stays the same, changes on cur_pos, fc1_low and fc2_low have no effect on the gates.
- R6: gate_comp is always the bitwise complement of gate_main.
- R7: The illegal codes 3'b011, 3'b100 and 3'b101 behave exactly like code 3'b000.
- R8: The gates reflect the inputs sampled at the previous rising clock edge, which is a latency of one cycle.
- R9: A synchronous active-high rst forces gate_main = 4'b0011 and gate_comp = 4'b1100, and leaves level 0 as the held level.
- R10: For non-negative levels, S3 and S4 stay at 1. For non-positive levels, S1 and S2 stay at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| level_code | input | 3 | Two's-complement level command |
| cur_pos | input | 1 | 1 = load current flows out of the leg |
| fc1_low | input | 1 | Positive-half capacitor below target |
| fc2_low | input | 1 | Negative-half capacitor below target |
| gate_main | output | 4 | Main gates {S1,S2,S3,S4} |
| gate_comp | output | 4 | Complementary gates |

## Verification
The bench applies every ordered pair of level codes (all eight codes, illegal ones included) under all eight combinations of current direction and capacitor flags. This separates the redundant choices at +1 and -1 and shows that each capacitor flag acts only on its own half. After each transition it holds the code and applies a second flag combination. This shows that the choice is latched on level entry rather than tracked. A reset applied in the middle of the run while +2 is commanded checks that the clamp pattern returns and that level 0 becomes the held level.

// File: rtl/leg_gate_pkg.sv
package leg_gate_pkg;
  localparam int CODE_W = 3;
  localparam int GATE_N = 4;
  localparam int HALF_N = GATE_N / 2;
  localparam int MAG_W  = 2;

  localparam logic [CODE_W-1:0] CODE_P2   = 3'b010;
  localparam logic [CODE_W-1:0] CODE_P1   = 3'b001;
  localparam logic [CODE_W-1:0] CODE_ZERO = 3'b000;
  localparam logic [CODE_W-1:0] CODE_N1   = 3'b111;
  localparam logic [CODE_W-1:0] CODE_N2   = 3'b110;

  localparam logic [GATE_N-1:0] GATES_CLAMP = 4'b0011;

  typedef struct packed {
    logic [MAG_W-1:0] pos_mag;
    logic [MAG_W-1:0] neg_mag;
  } half_cmd_t;
endpackage

// File: rtl/leg_level_split.sv
module leg_level_split
  import leg_gate_pkg::*;
(
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_norm,
  output half_cmd_t         halves
);
  always_comb begin
    unique case (code_in)
      CODE_P2, CODE_P1, CODE_N1, CODE_N2: code_norm = code_in;
      default:                            code_norm = CODE_ZERO;
    endcase
  end

  always_comb begin
    halves.pos_mag = '0;
    halves.neg_mag = '0;
    unique case (code_norm)
      CODE_P2: halves.pos_mag = 2'd2;
      CODE_P1: halves.pos_mag = 2'd1;
      CODE_N1: halves.neg_mag = 2'd1;
      CODE_N2: halves.neg_mag = 2'd2;
      default: ;
    endcase
  end
endmodule

// File: rtl/leg_balance_pick.sv
module leg_balance_pick
  import leg_gate_pkg::*;
(
  input  logic [CODE_W-1:0] code_norm,
  input  logic              cur_pos,
  input  logic              fc1_low,
  input  logic              fc2_low,
  output logic              rail_sel
);
  // rail_sel = 1 picks the state through the outer dc rail of the active half.
  // Positive half: the outer state charges cap 1 with outbound current.
  // Negative half: the outer state discharges cap 2 with outbound current.
  always_comb begin
    if (code_norm == CODE_P1)
      rail_sel = (cur_pos == fc1_low);
    else if (code_norm == CODE_N1)
      rail_sel = (cur_pos != fc2_low);
    else
      rail_sel = 1'b0;
  end
endmodule

// File: rtl/leg_cell_decode.sv
module leg_cell_decode
  import leg_gate_pkg::*;
#(
  parameter bit NEG_CELL = 1'b0
) (
  input  logic [MAG_W-1:0]  mag,
  input  logic              rail_sel,
  output logic [HALF_N-1:0] gates
);
  logic [HALF_N-1:0] base;

  always_comb begin
    unique case (mag)
      2'd2:    base = 2'b11;
      2'd1:    base = rail_sel ? 2'b10 : 2'b01;
      default: base = 2'b00;
    endcase
  end

  generate
    if (NEG_CELL) begin : g_neg
      assign gates = ~base;
    end else begin : g_pos
      assign gates = base;
    end
  endgenerate
endmodule

// File: rtl/leg_gate_decoder.sv
module leg_gate_decoder
  import leg_gate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] level_code,
  input  logic              cur_pos,
  input  logic              fc1_low,
  input  logic              fc2_low,
  output logic [GATE_N-1:0] gate_main,
  output logic [GATE_N-1:0] gate_comp
);
  logic [CODE_W-1:0] code_norm;
  half_cmd_t         halves;
  logic              rail_new;
  logic [CODE_W-1:0] level_q;
  logic              rail_q;
  logic              rail_use;
  logic [HALF_N-1:0] pos_gates;
  logic [HALF_N-1:0] neg_gates;
  logic [GATE_N-1:0] gate_d;

  leg_level_split u_split (
    .code_in   (level_code),
    .code_norm (code_norm),
    .halves    (halves)
  );

  leg_balance_pick u_pick (
    .code_norm (code_norm),
    .cur_pos   (cur_pos),
    .fc1_low   (fc1_low),
    .fc2_low   (fc2_low),
    .rail_sel  (rail_new)
  );

  // Choice is taken on level entry and kept while the level is unchanged.
  assign rail_use = (code_norm != level_q) ? rail_new : rail_q;

  leg_cell_decode #(.NEG_CELL(1'b0)) u_pos_cell (
    .mag      (halves.pos_mag),
    .rail_sel (rail_use),
    .gates    (pos_gates)
  );

  leg_cell_decode #(.NEG_CELL(1'b1)) u_neg_cell (
    .mag      (halves.neg_mag),
    .rail_sel (rail_use),
    .gates    (neg_gates)
  );

  assign gate_d = {pos_gates, neg_gates};

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q   <= CODE_ZERO;
      rail_q    <= 1'b0;
      gate_main <= GATES_CLAMP;
      gate_comp <= ~GATES_CLAMP;
    end else begin
      level_q   <= code_norm;
      rail_q    <= rail_use;
      gate_main <= gate_d;
      gate_comp <= ~gate_d;
    end
  end
endmodule

// File: rtl/leg_gate_decoder_chk.sv
module leg_gate_decoder_chk
  import leg_gate_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [CODE_W-1:0] level_code,
  input logic [GATE_N-1:0] gate_main,
  input logic [GATE_N-1:0] gate_comp
);
  // R6
  comp_match_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (gate_comp == ~gate_main));

  // R9
  reset_clamp_chk: assert property (@(posedge clk)
    $past(rst) |-> (gate_main == 4'b0011 && gate_comp == 4'b1100));

  // R1
  top_level_chk: assert property (@(posedge clk) disable iff (rst)
    (level_code == 3'b010) |=> (gate_main == 4'b1111));

  // R1
  bottom_level_chk: assert property (@(posedge clk) disable iff (rst)
    (level_code == 3'b110) |=> (gate_main == 4'b0000));

  // R7
  illegal_code_chk: assert property (@(posedge clk) disable iff (rst)
    (level_code == 3'b011 || level_code == 3'b100 || level_code == 3'b101)
      |=> (gate_main == 4'b0011));

  // R10
  pos_half_chk: assert property (@(posedge clk) disable iff (rst)
    (level_code == 3'b001 || level_code == 3'b010) |=> (gate_main[1:0] == 2'b11));

  // R10
  neg_half_chk: assert property (@(posedge clk) disable iff (rst)
    (level_code == 3'b111 || level_code == 3'b110) |=> (gate_main[3:2] == 2'b00));

  // R5
  hold_choice_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && level_code == $past(level_code)) |=> $stable(gate_main));
endmodule

bind leg_gate_decoder leg_gate_decoder_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .level_code (level_code),
  .gate_main  (gate_main),
  .gate_comp  (gate_comp)
);

// File: tb/leg_gate_decoder_bench.sv
`timescale 1ns/1ps
module leg_gate_decoder_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [2:0] level_code;
  logic       cur_pos, fc1_low, fc2_low;
  logic [3:0] gate_main, gate_comp;

  int checks = 0;
  int errors = 0;

  logic [2:0] exp_lvl;
  logic [3:0] exp_pat;

  always #10 clk = ~clk;

  leg_gate_decoder u_leg_gate_decoder (
    .clk(clk), .rst(rst), .level_code(level_code), .cur_pos(cur_pos),
    .fc1_low(fc1_low), .fc2_low(fc2_low), .gate_main(gate_main), .gate_comp(gate_comp)
  );

  function automatic logic [2:0] norm(input logic [2:0] c);
    if (c == 3'b010 || c == 3'b001 || c == 3'b111 || c == 3'b110) return c;
    return 3'b000;
  endfunction

  function automatic logic [3:0] pattern(input logic [2:0] c, input logic [2:0] f);
    // f = {cur_pos, fc1_low, fc2_low}
    case (c)
      3'b010:  return 4'b1111;
      3'b001:  return (f[2] == f[1]) ? 4'b1011 : 4'b0111;
      3'b111:  return (f[2] == f[0]) ? 4'b0010 : 4'b0001;
      3'b110:  return 4'b0000;
      default: return 4'b0011;
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] c);
    case (c)
      3'b010, 3'b110:         return "R1";
      3'b000:                 return "R2";
      3'b001:                 return "R3";
      3'b111:                 return "R4";
      default:                return "R7";
    endcase
  endfunction

  task automatic check(input string tag);
    checks++;
    if (gate_main !== exp_pat || gate_comp !== ~exp_pat) begin
      errors++;
      $display("FAIL %s main=%b comp=%b expected main=%b comp=%b",
               tag, gate_main, gate_comp, exp_pat, ~exp_pat);
    end
  endtask

  task automatic step(input logic [2:0] c, input logic [2:0] f, input string tag);
    @(negedge clk);
    level_code = c;
    {cur_pos, fc1_low, fc2_low} = f;
    if (norm(c) != exp_lvl) begin
      exp_lvl = norm(c);
      exp_pat = pattern(exp_lvl, f);
    end
    @(posedge clk);
    #2;
    // R8: output sampled one edge after the inputs were applied
    // R6: complement checked in every check
    check(tag);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1;
    level_code = 3'b010;
    {cur_pos, fc1_low, fc2_low} = 3'b000;
    exp_lvl = 3'b000;
    exp_pat = 4'b0011;
    repeat (3) @(posedge clk);
    #2;
    check("R9");
    @(negedge clk);
    rst = 1'b0;
    for (int p = 0; p < 8; p++) begin
      for (int n = 0; n < 8; n++) begin
        for (int f = 0; f < 8; f++) begin
          step(3'(p), 3'(f), tag_of(norm(3'(p))));
          step(3'(n), 3'(f), tag_of(norm(3'(n))));
          // R5: flags change, code held
          step(3'(n), 3'(7 - f), "R5");
          // R10: half separation follows from the expected pattern
        end
      end
    end
    // R9: reset mid-run while +2 is commanded
    step(3'b010, 3'b000, "R1");
    @(negedge clk);
    rst = 1'b1;
    exp_lvl = 3'b000;
    exp_pat = 4'b0011;
    @(posedge clk);
    #2;
    check("R9");
    @(negedge clk);
    rst = 1'b0;
    level_code = 3'b000;
    step(3'b000, 3'b101, "R9");
    step(3'b001, 3'b110, "R3");
    step(3'b111, 3'b101, "R4");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule